// File: doc/BRIEF.md
# Octal DAC Serial Command Controller

This block is the digital front end of an eight-channel, 8-bit voltage-output converter. A host writes 16-bit command words over a three-wire serial link made of a shift clock, a data line and an active-low select/load line. The block shifts each word into a shift register. When the select line rises, it decodes the top four bits of the word as a control field. That field selects one of four actions: write one channel, write every channel, change nothing, or put the output stage to sleep. The next eight bits are the code to write. The last four bits are padding.

The eight code registers drive the converter cores directly. A single flag tells the output stage to go high-impedance during sleep. The last shift stage is brought out as a serial output, so several devices can share the clock and load lines and be chained into one long shift path that updates on a single load edge. The serial pins are sampled on the block clock, which must run fast enough to see every level of the shift clock. An active-low asynchronous clear resets everything.

Top module: `octdac_ctrl`

## Requirements
- R1: While `cs_ni` is high, rising edges of `sclk_i` do not shift; the shift register, `sdo_o` and the codes do not change.
- R2: While `cs_ni` is low, each rising edge of `sclk_i` shifts `sdi_i` in, MSB first. After 16 shifts the first four bits are the control field, the next eight are the code (bit 7 first), and the last four are ignored.
- R3: A low-to-high transition of `cs_ni` applies the word in the clock cycle where the high level is first sampled. Control value k, for k = 1 to 8, writes the code into channel k-1, which is `code_o[8*(k-1) +: 8]`. All other channels are left as they were.
- R4: Control value 4'b1111 writes the same code into all eight channels.
- R5: Control values 4'b0000 and 4'b1001 to 4'b1101 leave every code unchanged.
- R6: Control value 4'b1110 sets `hiz_o` and ignores the code field. While `hiz_o` is set, all codes keep their values.
- R7: A load with any control value other than 4'b1110 clears `hiz_o`. A wake that writes one channel leaves the other channels at their stored codes.
- R8: `sdo_o` shows the last shift stage. A bit applied at `sdi_i` appears at `sdo_o` after the 16th shift counted from the shift that took it in, and `sdo_o` changes only on a shift.
- R9: Driving `rst_ni` low at once zeroes all codes and the shift register (`sdo_o` = 0) and clears `hiz_o`, without waiting for a clock.
- R10: A load after fewer than 16 shifts applies whatever the shift register holds at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; samples all serial pins |
| rst_ni | input | 1 | Asynchronous active-low clear |
| sclk_i | input | 1 | Serial shift clock, rising edge active |
| sdi_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Active-low select; its rising edge loads the word |
| sdo_o | output | 1 | Serial data out, for chaining |
| code_o | output | 64 | Eight 8-bit channel codes, channel 0 in the low byte |
| hiz_o | output | 1 | Sleep: output stage high-impedance |

## Verification
A shift and a load each take effect at the first block-clock edge that samples the new pin level. So `sdo_o` and `code_o` hold their new values one block-clock cycle after the stimulus was applied. The bench changes the pins on falling edges and reads the outputs on the next falling edge, half a cycle after the update. For the chain latency, the bench reads `sdo_o` after every single shift of a 32-bit stream and compares it with the bit applied 16 shifts earlier. The asynchronous clear is checked a few nanoseconds after `rst_ni` falls, before any clock edge.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam logic [3:0] CTL_SLEEP = 4'hE;
  localparam logic [3:0] CTL_ALL   = 4'hF;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ONE   = 2'd1,
    OP_ALL   = 2'd2,
    OP_SLEEP = 2'd3
  } op_e;
endpackage

// File: rtl/octdac_edge.sv
module octdac_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= RST_VAL;
    else         q <= d_i;

  assign rise_o = d_i & ~q;
endmodule

// File: rtl/octdac_shift.sv
module octdac_shift #(
  parameter int WORD_W = 16,
  parameter int HEAD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              d_i,
  output logic [HEAD_W-1:0] head_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   sr <= '0;
    else if (en_i) sr <= {sr[WORD_W-2:0], d_i};

  assign head_o = sr[WORD_W-1 -: HEAD_W];
  assign sdo_o  = sr[WORD_W-1];
endmodule

// File: rtl/octdac_decode.sv
module octdac_decode
  import octdac_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CTL_W  = 4
) (
  input  logic [CTL_W-1:0] ctl_i,
  output op_e              op_o,
  output logic [N_CH-1:0]  wr_mask_o
);
  logic is_all, is_sleep;

  assign is_all   = (ctl_i == CTL_ALL);
  assign is_sleep = (ctl_i == CTL_SLEEP);

  for (genvar k = 0; k < N_CH; k++) begin : g_sel
    assign wr_mask_o[k] = is_all | (ctl_i == CTL_W'(k + 1));
  end

  always_comb begin
    if (is_sleep)        op_o = OP_SLEEP;
    else if (is_all)     op_o = OP_ALL;
    else if (|wr_mask_o) op_o = OP_ONE;
    else                 op_o = OP_NONE;
  end
endmodule

// File: rtl/octdac_bank.sv
module octdac_bank #(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [N_CH-1:0]             wr_mask_i,
  input  logic [CODE_W-1:0]           code_i,
  output logic [N_CH-1:0][CODE_W-1:0] code_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                        code_o[k] <= '0;
      else if (load_i && wr_mask_i[k])    code_o[k] <= code_i;
  end
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8,
  parameter int CTL_W  = 4,
  parameter int PAD_W  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdi_i,
  input  logic                 cs_ni,
  output logic                 sdo_o,
  output logic [N_CH*CODE_W-1:0] code_o,
  output logic                 hiz_o
);
  localparam int HEAD_W = CTL_W + CODE_W;
  localparam int WORD_W = HEAD_W + PAD_W;

  logic                        sclk_rise, cs_rise;
  logic                        shift_en, load_en;
  logic [HEAD_W-1:0]           head;
  logic [CTL_W-1:0]            ctl;
  logic [CODE_W-1:0]           code_fld;
  logic [N_CH-1:0]             wr_mask;
  op_e                         op;
  logic [N_CH-1:0][CODE_W-1:0] codes;
  logic                        sleep_q;

  octdac_edge #(.RST_VAL(1'b1)) u_sclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .rise_o(sclk_rise)
  );

  octdac_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .rise_o(cs_rise)
  );

  assign shift_en = sclk_rise & ~cs_ni;
  assign load_en  = cs_rise;

  octdac_shift #(.WORD_W(WORD_W), .HEAD_W(HEAD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(shift_en), .d_i(sdi_i),
    .head_o(head), .sdo_o(sdo_o)
  );

  assign ctl      = head[HEAD_W-1 -: CTL_W];
  assign code_fld = head[CODE_W-1:0];

  octdac_decode #(.N_CH(N_CH), .CTL_W(CTL_W)) u_dec (
    .ctl_i(ctl), .op_o(op), .wr_mask_o(wr_mask)
  );

  octdac_bank #(.N_CH(N_CH), .CODE_W(CODE_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_en),
    .wr_mask_i(wr_mask), .code_i(code_fld), .code_o(codes)
  );

  // every load either enters or leaves sleep
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sleep_q <= 1'b0;
    else if (load_en) sleep_q <= (op == OP_SLEEP);

  assign code_o = codes;
  assign hiz_o  = sleep_q;
endmodule

// File: rtl/octdac_ctrl_chk.sv
module octdac_ctrl_chk
  import octdac_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   sdo_o,
  input logic [N_CH*CODE_W-1:0] code_o,
  input logic                   hiz_o,
  input logic                   load_en,
  input op_e                    op
);
  function automatic logic all_same(input logic [N_CH*CODE_W-1:0] v);
    logic ok = 1'b1;
    for (int k = 1; k < N_CH; k++)
      if (v[k*CODE_W +: CODE_W] != v[CODE_W-1:0]) ok = 1'b0;
    return ok;
  endfunction

  a_r1_no_shift_when_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(sdo_o));

  a_r3_codes_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> $stable(code_o));

  a_r4_all_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && op == OP_ALL) |=> all_same(code_o));

  a_r6_sleep_keeps_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> $stable(code_o));

  a_r7_wake_on_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && op != OP_SLEEP) |=> !hiz_o);

  a_r6_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && op == OP_SLEEP) |=> hiz_o);
endmodule

bind octdac_ctrl octdac_ctrl_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sdo_o(sdo_o),
  .code_o(code_o), .hiz_o(hiz_o), .load_en(load_en), .op(op)
);

// File: tb/tb_octdac_ctrl.sv
module tb_octdac_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic sdo_a, sdo_b, hiz_a, hiz_b;
  logic [N*8-1:0] code_a, code_b;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  octdac_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi), .cs_ni(cs_n),
    .sdo_o(sdo_a), .code_o(code_a), .hiz_o(hiz_a)
  );

  octdac_ctrl dut_far (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdo_a), .cs_ni(cs_n),
    .sdo_o(sdo_b), .code_o(code_b), .hiz_o(hiz_b)
  );

  // {control, code}
  localparam logic [11:0] VEC [14] = '{
    {4'h1, 8'h3C}, {4'h8, 8'hA5}, {4'hF, 8'h5A}, {4'h4, 8'h01},
    {4'h0, 8'hFF}, {4'h9, 8'h77}, {4'hD, 8'h88}, {4'hE, 8'hEE},
    {4'hE, 8'h00}, {4'h6, 8'h42}, {4'hE, 8'h99}, {4'hB, 8'h12},
    {4'h2, 8'hFF}, {4'h7, 8'h80}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic sel;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic load;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  function automatic string req_of(input logic [3:0] c);
    if (c >= 4'h1 && c <= 4'h8) return "R3";
    if (c == 4'hF) return "R4";
    if (c == 4'hE) return "R6";
    return "R5";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [7:0] model [N];
    logic       msleep;
    logic [31:0] stream;

    repeat (2) @(negedge clk);
    // R9: reset state
    chk(code_a == '0, "R9 codes at reset", code_a[31:0], 0);
    chk(hiz_a == 1'b0, "R9 hiz at reset", hiz_a, 0);
    chk(sdo_a == 1'b0, "R9 sdo at reset", sdo_a, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < N; k++) model[k] = 8'h00;
    msleep = 1'b0;

    // R2 R3 R4 R5 R6 R7: vector walk
    foreach (VEC[i]) begin
      logic [3:0] c;
      logic [7:0] d;
      c = VEC[i][11:8];
      d = VEC[i][7:0];
      sel();
      send_bits({16'h0, c, d, 4'hA}, 16);
      load();
      if (c >= 4'h1 && c <= 4'h8) model[c - 1] = d;
      if (c == 4'hF) for (int k = 0; k < N; k++) model[k] = d;
      msleep = (c == 4'hE);
      for (int k = 0; k < N; k++)
        chk(code_a[k*8 +: 8] == model[k], req_of(c), code_a[k*8 +: 8], model[k]);
      chk(hiz_a == msleep, msleep ? "R6 hiz set" : "R7 hiz clear", hiz_a, msleep);
    end

    // R8: serial output latency over a 32-bit stream
    do_reset();
    stream = 32'hB38E_5AC1;
    sel();
    for (int i = 1; i <= 32; i++) begin
      logic e;
      send_bit(stream[32 - i]);
      e = (i >= 16) ? stream[47 - i] : 1'b0;
      chk(sdo_a == e, "R8 sdo delay", sdo_a, e);
    end
    load();

    // R1: clock ignored while select is high
    do_reset();
    sel(); send_bits({16'h0, 4'h1, 8'h11, 4'hA}, 16); load();
    chk(code_a[7:0] == 8'h11, "R3 ch0 write", code_a[7:0], 8'h11);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    chk(sdo_a == 1'b0, "R1 sdo unchanged", sdo_a, 0);
    chk(code_a[7:0] == 8'h11, "R1 code unchanged", code_a[7:0], 8'h11);

    // R10: short word uses what the register holds (0x111A -> 0x11A5)
    sel(); send_bits(32'h5, 4); load();
    chk(code_a[7:0] == 8'h1A, "R10 short word code", code_a[7:0], 8'h1A);
    chk(code_a[15:8] == 8'h00, "R10 other channel", code_a[15:8], 0);

    // R8 R2: two-device chain, far word sent first
    do_reset();
    sel();
    send_bits({16'h0, 4'h3, 8'hC3, 4'h0}, 16);
    send_bits({16'h0, 4'h5, 8'h96, 4'hF}, 16);
    load();
    chk(code_b[23:16] == 8'hC3, "R8 chain far ch2", code_b[23:16], 8'hC3);
    chk(code_a[39:32] == 8'h96, "R8 chain near ch4", code_a[39:32], 8'h96);
    chk(code_b[39:32] == 8'h00, "R8 chain far ch4", code_b[39:32], 0);
    chk(code_a[23:16] == 8'h00, "R8 chain near ch2", code_a[23:16], 0);
    sel();
    send_bits({16'h0, 4'hE, 8'h00, 4'h0}, 16);
    send_bits({16'h0, 4'hF, 8'h6D, 4'h0}, 16);
    load();
    chk(hiz_b == 1'b1, "R6 chain far sleep", hiz_b, 1);
    chk(code_b[23:16] == 8'hC3, "R6 chain far kept", code_b[23:16], 8'hC3);
    chk(hiz_a == 1'b0, "R7 chain near awake", hiz_a, 0);
    chk(code_a[63:56] == 8'h6D && code_a[7:0] == 8'h6D, "R4 chain near all", code_a[31:0], 32'h6D6D6D6D);

    // R9: asynchronous clear between clock edges
    @(negedge clk); #2 rst_ni = 1'b0;
    #1;
    chk(code_a == '0, "R9 async codes", code_a[31:0], 0);
    chk(code_b == '0, "R9 async far codes", code_b[31:0], 0);
    chk(hiz_b == 1'b0, "R9 async hiz", hiz_b, 0);
    chk(sdo_a == 1'b0, "R9 async sdo", sdo_a, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule